// File: doc/BRIEF.md
# Carrier Sense and Collision Generator

This block produces the media-independent-interface carrier sense and collision signals of a 100 Mb/s fiber physical layer. It also drives an active-low link activity lamp output. It takes a receive-activity flag that is already in the receive clock domain and goes high while non-idle line symbols arrive. It also takes the transmit enable from the MAC, which comes from the transmit clock domain and is resynchronised inside the block. Every output is registered on the receive clock, so each one changes only at a clock edge and has no glitches.

Three configuration bits choose the operating mode: full duplex, repeater and loopback. With none set, the block runs in the default half-duplex mode. In that mode carrier follows either direction of activity, and simultaneous activity in both directions is a collision. Repeater mode forces half duplex and restricts carrier to receive activity. Full duplex also restricts carrier to receive activity. Collision is suppressed in full duplex, in repeater mode and in loopback. The effective duplex is brought out on its own pin so the MAC can follow it.

Top module: `crs_col_unit`

## Requirements
- R1: While rst_n is low, crs and col are 0, link_act_n is 1 and duplex_eff is 0.
- R2: With no mode bit set (default half duplex), crs is 1 when rx_active is 1 or the synchronised tx_en is 1.
- R3: crs is 0 when rx_active is 0 and the synchronised tx_en is 0, in every mode.
- R4: With cfg_repeater or cfg_full_duplex set to 1, crs equals rx_active and ignores tx_en.
- R5: In default mode, col is 1 for as long as rx_active and the synchronised tx_en are both 1. Otherwise col is 0.
- R6: col is 0 whenever cfg_full_duplex, cfg_repeater or cfg_loopback is 1, even when both directions are active.
- R7: duplex_eff is cfg_full_duplex AND NOT cfg_repeater, so setting the repeater bit forces half duplex.
- R8: link_act_n is 0 while rx_active is 1 and is 1 otherwise.
- R9: A change on rx_active or a configuration bit reaches the outputs at the next rx_clk rising edge. A change on tx_en passes through SYNC_STAGES flops (default 2) and reaches crs and col at rising edge SYNC_STAGES+1, which is the third edge by default.
- R10: In loopback mode with neither full duplex nor repeater set, crs follows either direction of activity, as in default mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Receive clock; every output is registered on its rising edge |
| rst_n | input | 1 | Active-low reset, applied synchronously to rx_clk |
| rx_active | input | 1 | Non-idle receive symbols are present, in the rx_clk domain |
| tx_en | input | 1 | Transmit enable from the MAC, asynchronous to rx_clk |
| cfg_full_duplex | input | 1 | Full-duplex request |
| cfg_repeater | input | 1 | Repeater mode; forces half duplex |
| cfg_loopback | input | 1 | Loopback mode; suppresses collision |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision |
| link_act_n | output | 1 | Active-low receive activity indicator |
| duplex_eff | output | 1 | Effective full duplex after the repeater override |

## Verification
The assertions check several rules on every cycle. Collision appears only when both directions were active one edge earlier. Collision stays quiet in the suppressing modes. Carrier equals receive activity in the receive-only modes, and idle in both directions gives no carrier. The lamp is the inverse of the receive flag, and repeater mode keeps duplex_eff low. These checks work from the synchronised transmit flag. Only the bench scenarios show the synchronizer latency counted from the raw tx_en pin, that collision persists across a long overlap, and how loopback carrier behaves.

// File: rtl/crs_col_pkg.sv
package crs_col_pkg;

  // Per-mode controls derived from the configuration bits.
  typedef struct packed {
    logic duplex_full;  // effective full duplex
    logic crs_rx_only;  // carrier ignores transmit activity
    logic col_allow;    // collision may be reported
  } mode_ctl_t;

  function automatic mode_ctl_t decode_mode(input logic fd, input logic rep,
                                            input logic lb);
    mode_ctl_t m;
    m.duplex_full = fd & ~rep;
    m.crs_rx_only = rep | m.duplex_full;
    m.col_allow   = ~(m.duplex_full | rep | lb);
    return m;
  endfunction

  function automatic logic carrier_of(input logic rx, input logic tx,
                                      input logic rx_only);
    return rx | (tx & ~rx_only);
  endfunction

  function automatic logic collision_of(input logic rx, input logic tx,
                                        input logic allow);
    return rx & tx & allow;
  endfunction

endpackage

// File: rtl/cdc_sync_bits.sv
module cdc_sync_bits #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[LAST];
endmodule

// File: rtl/crs_mode_decode.sv
module crs_mode_decode
  import crs_col_pkg::*;
(
  input  logic      cfg_full_duplex,
  input  logic      cfg_repeater,
  input  logic      cfg_loopback,
  output mode_ctl_t mode
);
  always_comb mode = decode_mode(cfg_full_duplex, cfg_repeater, cfg_loopback);
endmodule

// File: rtl/crs_col_core.sv
module crs_col_core
  import crs_col_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rx_act,
  input  logic      tx_act,
  input  mode_ctl_t mode,
  output logic      crs_q,
  output logic      col_q,
  output logic      link_n_q,
  output logic      dup_q
);
  logic crs_d, col_d;

  always_comb begin
    crs_d = carrier_of(rx_act, tx_act, mode.crs_rx_only);
    col_d = collision_of(rx_act, tx_act, mode.col_allow);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crs_q    <= 1'b0;
      col_q    <= 1'b0;
      link_n_q <= 1'b1;
      dup_q    <= 1'b0;
    end else begin
      crs_q    <= crs_d;
      col_q    <= col_d;
      link_n_q <= ~rx_act;
      dup_q    <= mode.duplex_full;
    end
  end
endmodule

// File: rtl/crs_col_unit.sv
module crs_col_unit
  import crs_col_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic rx_clk,
  input  logic rst_n,
  input  logic rx_active,
  input  logic tx_en,
  input  logic cfg_full_duplex,
  input  logic cfg_repeater,
  input  logic cfg_loopback,
  output logic crs,
  output logic col,
  output logic link_act_n,
  output logic duplex_eff
);
  logic      tx_sync;      // transmit enable in the rx_clk domain
  mode_ctl_t mode;
  logic      col_allow;    // named for the checker
  logic      crs_rx_only;  // named for the checker

  cdc_sync_bits #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_tx_sync (
    .clk(rx_clk), .rst_n(rst_n), .d(tx_en), .q(tx_sync)
  );

  crs_mode_decode u_mode (
    .cfg_full_duplex(cfg_full_duplex), .cfg_repeater(cfg_repeater),
    .cfg_loopback(cfg_loopback), .mode(mode)
  );

  assign col_allow   = mode.col_allow;
  assign crs_rx_only = mode.crs_rx_only;

  crs_col_core u_core (
    .clk(rx_clk), .rst_n(rst_n), .rx_act(rx_active), .tx_act(tx_sync),
    .mode(mode), .crs_q(crs), .col_q(col), .link_n_q(link_act_n),
    .dup_q(duplex_eff)
  );
endmodule

// File: rtl/crs_col_checker.sv
module crs_col_checker (
  input logic clk,
  input logic rst_n,
  input logic rx_active,
  input logic tx_sync,
  input logic cfg_full_duplex,
  input logic cfg_repeater,
  input logic cfg_loopback,
  input logic crs,
  input logic col,
  input logic link_act_n,
  input logic duplex_eff
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(!rst_n) && !rst_n |-> !crs && !col && link_act_n && !duplex_eff); // R1

  AST_COL_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && col |-> $past(rx_active) && $past(tx_sync)); // R5

  AST_COL_SUPPRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(cfg_full_duplex || cfg_repeater || cfg_loopback) |-> !col); // R6

  AST_CRS_RX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(cfg_full_duplex || cfg_repeater) |-> crs == $past(rx_active)); // R4

  AST_IDLE_NO_CRS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(!rx_active && !tx_sync) |-> !crs); // R3

  AST_LINK_LAMP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> link_act_n == !$past(rx_active)); // R8

  AST_REPEATER_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(cfg_repeater) |-> !duplex_eff); // R7
endmodule

bind crs_col_unit crs_col_checker u_chk (
  .clk(rx_clk), .rst_n(rst_n), .rx_active(rx_active), .tx_sync(tx_sync),
  .cfg_full_duplex(cfg_full_duplex), .cfg_repeater(cfg_repeater),
  .cfg_loopback(cfg_loopback), .crs(crs), .col(col),
  .link_act_n(link_act_n), .duplex_eff(duplex_eff)
);

// File: tb/test_crs_col_unit.sv
`timescale 1ns/1ps
module test_crs_col_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_active = 1'b0, tx_en = 1'b0;
  logic fd = 1'b0, rep = 1'b0, lb = 1'b0;
  logic crs, col, link_act_n, duplex_eff;
  int checks = 0, failures = 0;

  always #4 clk = ~clk; // 125 MHz

  crs_col_unit i_crs_col_unit (
    .rx_clk(clk), .rst_n(rst_n), .rx_active(rx_active), .tx_en(tx_en),
    .cfg_full_duplex(fd), .cfg_repeater(rep), .cfg_loopback(lb),
    .crs(crs), .col(col), .link_act_n(link_act_n), .duplex_eff(duplex_eff)
  );

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", what, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Apply stimulus, wait until the tx path has settled, check all outputs.
  task automatic apply(input logic r, input logic t, input logic exp_crs,
                       input logic exp_col, input string tag);
    rx_active = r; tx_en = t;
    settle(4);
    check(crs, exp_crs, {tag, " crs"});
    check(col, exp_col, {tag, " col"});
    check(link_act_n, ~r, "R8 link_act_n");
  endtask

  task automatic t_reset;
    rx_active = 1'b1; tx_en = 1'b1; fd = 1'b1;
    settle(4);
    check(crs, 1'b0, "R1 crs in reset");
    check(col, 1'b0, "R1 col in reset");
    check(link_act_n, 1'b1, "R1 link_act_n in reset");
    check(duplex_eff, 1'b0, "R1 duplex_eff in reset");
    rx_active = 1'b0; tx_en = 1'b0; fd = 1'b0;
    rst_n = 1'b1;
    settle(4);
  endtask

  task automatic t_default;
    apply(1'b1, 1'b0, 1'b1, 1'b0, "R2 rx only");
    apply(1'b0, 1'b1, 1'b1, 1'b0, "R2 tx only");
    apply(1'b1, 1'b1, 1'b1, 1'b1, "R5 both active");
    settle(6);
    check(col, 1'b1, "R5 col persists");
    apply(1'b0, 1'b0, 1'b0, 1'b0, "R3 both idle");
    check(duplex_eff, 1'b0, "R7 default half");
  endtask

  task automatic t_latency;
    // driven at a falling edge; outputs sampled at following falling edges
    tx_en = 1'b1;
    settle(2);
    check(crs, 1'b0, "R9 tx not yet through sync");
    settle(1);
    check(crs, 1'b1, "R9 tx after third edge");
    tx_en = 1'b0;
    settle(4);
    rx_active = 1'b1;
    settle(1);
    check(crs, 1'b1, "R9 rx after one edge");
    check(link_act_n, 1'b0, "R9 R8 lamp after one edge");
    rx_active = 1'b0;
    settle(1);
    check(link_act_n, 1'b1, "R8 lamp released");
    settle(3);
  endtask

  task automatic t_repeater;
    rep = 1'b1; fd = 1'b1;
    settle(1);
    check(duplex_eff, 1'b0, "R7 repeater forces half");
    apply(1'b0, 1'b1, 1'b0, 1'b0, "R4 repeater tx ignored");
    apply(1'b1, 1'b1, 1'b1, 1'b0, "R6 repeater no col");
    apply(1'b0, 1'b0, 1'b0, 1'b0, "R3 repeater idle");
    rep = 1'b0;
    settle(1);
    check(duplex_eff, 1'b1, "R7 full duplex effective");
    apply(1'b0, 1'b1, 1'b0, 1'b0, "R4 full duplex tx ignored");
    apply(1'b1, 1'b1, 1'b1, 1'b0, "R6 full duplex no col");
    apply(1'b1, 1'b0, 1'b1, 1'b0, "R4 full duplex rx");
    apply(1'b0, 1'b0, 1'b0, 1'b0, "R3 full duplex idle");
    fd = 1'b0;
    settle(2);
  endtask

  task automatic t_loopback;
    lb = 1'b1;
    apply(1'b1, 1'b1, 1'b1, 1'b0, "R6 loopback no col");
    apply(1'b0, 1'b1, 1'b1, 1'b0, "R10 loopback tx carrier");
    apply(1'b0, 1'b0, 1'b0, 1'b0, "R3 loopback idle");
    check(duplex_eff, 1'b0, "R7 loopback half");
    lb = 1'b0;
    apply(1'b1, 1'b1, 1'b1, 1'b1, "R5 col returns after loopback");
    apply(1'b0, 1'b0, 1'b0, 1'b0, "R3 final idle");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_default();
    t_latency();
    t_repeater();
    t_loopback();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule